// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider with Bias and DAC Timing Enables

This block is the programmable feedback divider of a fractional-N synthesizer, written as synchronous logic on the fast clock it divides. A chain of divide-by-two cells, each able to absorb one extra input cycle per output cycle, sets the output period to 2^NSTG plus a swallow code. With the default of seven cells the modulus spans 128 to 255. Each output cycle a new swallow code comes from the noise-shaping modulator. It is sampled only in the cycle that closes the running output period, and `cyc_end_o` marks that cycle so the modulator can step.

The divided output is taken from a level that is high for the first half of each period. It passes through a short chain of plain registers, so every rising edge lands a fixed number of cycles after the period boundary, whatever the modulus. Two timing enables are produced and aligned to that edge. One is a power-up window for the charge-pump bias generator: one eighth of the period long, closing a small fixed gap before the edge. The other is a fixed-width enable for the cancellation DAC, centred on the edge so that it overlaps the charge-pump pulse.

Top module: `pswallow_divider`

## Requirements
- R1: While `rst_ni` is low, `cyc_end_o`, `div_o`, `bias_en_o` and `dac_en_o` are all low.
- R2: Counting the cycle in which `rst_ni` is released as cycle 0, the first `cyc_end_o` pulse is in cycle 2^NSTG-1 (127). After that, the distance between consecutive pulses is 2^NSTG plus the value of `mod_code_i` in the earlier pulse's cycle.
- R3: `mod_code_i` has no effect in any cycle in which `cyc_end_o` is low.
- R4: `div_o` rises exactly once per period, in the third cycle after a `cyc_end_o` cycle. It stays high for floor(M/2) cycles and is low for the rest of the period, where M is the modulus that period was loaded with.
- R5: `div_o` stays low from reset until the first `cyc_end_o` pulse.
- R6: `dac_en_o` is high for DAC_W (8) consecutive cycles around each `div_o` rising edge. It starts DAC_W/2 cycles before the first high cycle of `div_o` and ends DAC_W/2-1 cycles after it. This includes the pulse for the first edge after reset.
- R7: `bias_en_o` is high for floor(M/8) consecutive cycles, where M is the modulus of the period that ends at the next `div_o` edge (128 for the first period). The window ends so that exactly BIAS_GAP (2) low cycles come before that edge, and it never overlaps `div_o`.
- R8: `cyc_end_o` is high for a single cycle at a time.
- R9: The extreme swallow codes give the extreme moduli: code 0 gives a 128-cycle period and code 127 gives a 255-cycle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock being divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mod_code_i | input | NSTG | Swallow code; modulus is 2^NSTG plus this value |
| cyc_end_o | output | 1 | High in the cycle that closes an output period; code is sampled here |
| div_o | output | 1 | Retimed divided output |
| bias_en_o | output | 1 | Charge-pump bias power-up window |
| dac_en_o | output | 1 | Cancellation DAC pulse enable centred on the divider edge |

## Verification
The bench drives a garbage swallow code in every cycle except the boundary cycle. A divider that samples its modulus at the wrong moment therefore produces wrong periods at once. The moduli at both ends of the range are placed next to each other. This shows a swallow chain that drops or double-counts its top or bottom cell as an off-by-power-of-two period. Every cycle of both enables is compared with a window model built from the boundary positions. A DAC pulse that starts at the edge instead of straddling it, or a bias window sized from the wrong period, shows up as single-cycle mismatches. A reset in the middle of a period checks that the first period after release is again the minimum one, and that no stray edge or enable appears before the first boundary.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

   // Timing outputs carried together through the retiming pipeline.
   typedef struct packed {
      logic div;
      logic bias;
      logic dac;
   } pd_tim_t;

   localparam int unsigned PD_TIM_W = $bits(pd_tim_t);

endpackage

// File: rtl/pswallow_stage.sv
// One divide-by-two cell that can absorb a single input tick per output
// cycle. An armed cell consumes its first tick without toggling.
module pswallow_stage (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic load_i,
   input  logic swallow_i,
   output logic tick_o
);

   logic tog_q;
   logic pend_q;

   // A tick passes on when the cell wraps from its second half to its first.
   assign tick_o = tick_i & ~pend_q & tog_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tog_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (tick_i) begin
            if (pend_q) pend_q <= 1'b0;
            else        tog_q  <= ~tog_q;
         end
         if (load_i) pend_q <= swallow_i;
      end
   end

endmodule

// File: rtl/pswallow_timing.sv
// Period phase tracking and raw (pre-retiming) timing windows.
module pswallow_timing
   import pswallow_pkg::*;
#(
   parameter int unsigned NSTG       = 7,
   parameter int unsigned DAC_W      = 8,
   parameter int unsigned BIAS_GAP   = 2,
   parameter int unsigned BIAS_SHIFT = 3
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            end_i,
   input  logic [NSTG-1:0] code_i,
   output pd_tim_t         raw_o
);

   localparam int unsigned PW = NSTG + 1;
   localparam logic [PW-1:0] BASE_M = PW'(1) << NSTG;
   localparam logic [PW-1:0] HALF_C = PW'(DAC_W / 2);
   localparam logic [PW:0]   GAP_E  = (PW + 1)'(BIAS_GAP);

   logic [PW-1:0] ph_q, m_q;
   logic          seen_q;
   pd_tim_t       raw_q;

   logic [PW-1:0] ph_n, m_n, rem_n, bwin_n;
   logic          seen_n;
   pd_tim_t       raw_n;

   always_comb begin
      ph_n   = end_i ? '0 : ph_q + PW'(1);
      m_n    = end_i ? {1'b1, code_i} : m_q;
      seen_n = seen_q | end_i;
      // Cycles left before the boundary that closes the period.
      rem_n  = m_n - ph_n - PW'(1);
      bwin_n = m_n >> BIAS_SHIFT;

      raw_n.div  = seen_n & (ph_n < (m_n >> 1));
      raw_n.dac  = (rem_n < HALF_C) | (seen_n & (ph_n < HALF_C));
      raw_n.bias = ({1'b0, rem_n} >= GAP_E) &&
                   ({1'b0, rem_n} < (GAP_E + {1'b0, bwin_n}));
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ph_q   <= '0;
         m_q    <= BASE_M;
         seen_q <= 1'b0;
         raw_q  <= '0;
      end else begin
         ph_q   <= ph_n;
         m_q    <= m_n;
         seen_q <= seen_n;
         raw_q  <= raw_n;
      end
   end

   assign raw_o = raw_q;

endmodule

// File: rtl/pswallow_retime.sv
// Fixed-depth register chain giving every timing output the same latency.
module pswallow_retime #(
   parameter int unsigned W     = 1,
   parameter int unsigned DEPTH = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (DEPTH == 0) begin : g_pass
      assign q_o = d_i;
   end else begin : g_pipe
      logic [W-1:0] stg_q [DEPTH];

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            for (int j = 0; j < DEPTH; j++) stg_q[j] <= '0;
         end else begin
            stg_q[0] <= d_i;
            for (int j = 1; j < DEPTH; j++) stg_q[j] <= stg_q[j-1];
         end
      end

      assign q_o = stg_q[DEPTH-1];
   end

endmodule

// File: rtl/pswallow_divider.sv
module pswallow_divider
   import pswallow_pkg::*;
#(
   parameter int unsigned NSTG       = 7,
   parameter int unsigned DAC_W      = 8,
   parameter int unsigned BIAS_GAP   = 2,
   parameter int unsigned BIAS_SHIFT = 3,
   parameter int unsigned RETIME     = 2
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [NSTG-1:0] mod_code_i,
   output logic            cyc_end_o,
   output logic            div_o,
   output logic            bias_en_o,
   output logic            dac_en_o
);

   localparam int unsigned MIN_M = 1 << NSTG;

   if (NSTG < 2 || NSTG > 12) begin : g_bad_nstg
      $error("NSTG must lie in 2..12");
   end
   if (DAC_W < 2 || (DAC_W % 2) != 0 || DAC_W / 2 > MIN_M / 4) begin : g_bad_dac
      $error("DAC_W must be even, at least 2, and at most a half-period");
   end
   if (BIAS_SHIFT < 1 || BIAS_GAP + ((2 * MIN_M) >> BIAS_SHIFT) >= MIN_M / 2) begin : g_bad_bias
      $error("bias window must fit in the low half of the shortest period");
   end

   logic    cyc_end;
   pd_tim_t raw_tim;
   pd_tim_t out_tim;

   for (genvar i = 0; i < NSTG; i++) begin : g_stg
      logic tin;
      logic tout;
      if (i == 0) begin : g_head
         assign tin = 1'b1;
      end else begin : g_link
         assign tin = g_stg[i-1].tout;
      end
      pswallow_stage u_stage (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .tick_i    (tin),
         .load_i    (cyc_end),
         .swallow_i (mod_code_i[i]),
         .tick_o    (tout)
      );
   end

   assign cyc_end = g_stg[NSTG-1].tout;

   pswallow_timing #(
      .NSTG       (NSTG),
      .DAC_W      (DAC_W),
      .BIAS_GAP   (BIAS_GAP),
      .BIAS_SHIFT (BIAS_SHIFT)
   ) u_timing (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .end_i  (cyc_end),
      .code_i (mod_code_i),
      .raw_o  (raw_tim)
   );

   pswallow_retime #(
      .W     (PD_TIM_W),
      .DEPTH (RETIME)
   ) u_retime (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (raw_tim),
      .q_o    (out_tim)
   );

   assign cyc_end_o = cyc_end;
   assign div_o     = out_tim.div;
   assign bias_en_o = out_tim.bias;
   assign dac_en_o  = out_tim.dac;

endmodule

// File: rtl/pswallow_divider_chk.sv
module pswallow_divider_chk #(
   parameter int unsigned NSTG   = 7,
   parameter int unsigned RETIME = 2
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic [NSTG-1:0] mod_code_i,
   input logic            cyc_end_o,
   input logic            div_o,
   input logic            bias_en_o,
   input logic            dac_en_o
);

   localparam int unsigned CW = NSTG + 2;

   logic [CW-1:0]   since_q;
   logic [NSTG:0]   mcur_q;
   logic            seen_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         since_q <= '1;
         mcur_q  <= '0;
         seen_q  <= 1'b0;
      end else if (cyc_end_o) begin
         since_q <= '0;
         mcur_q  <= {1'b1, mod_code_i};
         seen_q  <= 1'b1;
      end else if (since_q != '1) begin
         since_q <= since_q + CW'(1);
      end
   end

   // R1: everything quiet while reset is held
   always @(posedge clk_i) begin
      if (!rst_ni) begin
         a_r1_quiet_in_reset: assert (!cyc_end_o && !div_o && !bias_en_o && !dac_en_o);
      end
   end

   a_r2_period_matches_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_end_o && seen_q) |-> (since_q == ({1'b0, mcur_q} - CW'(1))));

   a_r8_end_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cyc_end_o |=> !cyc_end_o);

   a_r4_rise_fixed_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(div_o) |-> (since_q == CW'(RETIME)));

   a_r5_no_edge_before_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !seen_q |-> !div_o);

   a_r6_dac_covers_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(div_o) |-> dac_en_o);

   a_r7_bias_clear_of_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bias_en_o |-> !div_o);

endmodule

bind pswallow_divider pswallow_divider_chk #(
   .NSTG   (NSTG),
   .RETIME (RETIME)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .mod_code_i (mod_code_i),
   .cyc_end_o  (cyc_end_o),
   .div_o      (div_o),
   .bias_en_o  (bias_en_o),
   .dac_en_o   (dac_en_o)
);

// File: tb/pswallow_divider_tb.sv
`timescale 1ns/1ps
module pswallow_divider_tb;

   localparam int NSTG = 7;
   localparam int HW   = 4;   // DAC_W / 2
   localparam int GAP  = 2;
   localparam int NC   = 10;
   // columns: swallow code, expected rise-to-rise period
   localparam int TBL [NC][2] = '{
      '{0, 128}, '{127, 255}, '{1, 129}, '{64, 192}, '{85, 213},
      '{42, 170}, '{127, 255}, '{0, 128}, '{3, 131}, '{100, 228}};

   logic            clk = 1'b0;
   logic            rst_ni = 1'b0;
   logic [NSTG-1:0] mod_code_i = '0;
   logic            cyc_end_o, div_o, bias_en_o, dac_en_o;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   int code_a [0:15];
   int per_a  [0:15];
   int ends   [0:16];
   int nseg;

   always #2 clk = ~clk;

   pswallow_divider u_dut (
      .clk_i      (clk),
      .rst_ni     (rst_ni),
      .mod_code_i (mod_code_i),
      .cyc_end_o  (cyc_end_o),
      .div_o      (div_o),
      .bias_en_o  (bias_en_o),
      .dac_en_o   (dac_en_o)
   );

   task automatic chk(input logic got, input logic exp, input string req, input int s);
      nchk++;
      if (got !== exp) begin
         nfail++;
         $display("FAIL %s state=%0d actual=%0b expected=%0b", req, s, got, exp);
      end
   endtask

   task automatic chk_int(input int got, input int exp, input string req);
      nchk++;
      if (got != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
      end
   endtask

   function automatic bit e_end(input int s);
      for (int k = 0; k <= nseg; k++) if (s == ends[k]) return 1'b1;
      return 1'b0;
   endfunction

   function automatic bit e_div(input int s);
      for (int k = 0; k < nseg; k++)
         if (s >= ends[k] + 3 && s <= ends[k] + 2 + per_a[k] / 2) return 1'b1;
      return 1'b0;
   endfunction

   function automatic bit e_dac(input int s);
      for (int k = 0; k <= nseg; k++)
         if (s >= ends[k] + 3 - HW && s <= ends[k] + 2 + HW) return 1'b1;
      return 1'b0;
   endfunction

   function automatic bit e_bias(input int s);
      for (int k = 0; k <= nseg; k++) begin
         int b = ((k == 0) ? 128 : per_a[k-1]) >> 3;
         if (s >= ends[k] - GAP - b + 3 && s <= ends[k] - GAP + 2) return 1'b1;
      end
      return 1'b0;
   endfunction

   // Called at the negedge where rst_ni has just been released (state 0).
   task automatic run_seq();
      int stop;
      int rc = 0;
      int last_rise = 0;
      logic prev_div = 1'b0;
      ends[0] = 127;
      for (int k = 0; k < nseg; k++) ends[k+1] = ends[k] + per_a[k];
      stop = ends[nseg] - 40;
      for (int s = 0; s <= stop; s++) begin
         chk(cyc_end_o, e_end(s), "R2 R8 boundary pulse", s);
         chk(div_o, e_div(s), "R4 R5 divided output", s);
         chk(dac_en_o, e_dac(s), "R6 dac window", s);
         chk(bias_en_o, e_bias(s), "R7 bias window", s);
         if (div_o && !prev_div) begin
            if (rc > 0) begin
               if (code_a[rc-1] == 0 || code_a[rc-1] == 127)
                  chk_int(s - last_rise, per_a[rc-1], "R9 extreme modulus period");
               else
                  chk_int(s - last_rise, per_a[rc-1], "R2 rise-to-rise period");
            end
            rc++;
            last_rise = s;
         end
         prev_div = div_o;
         // R3: only the boundary cycle carries the real code
         mod_code_i = 7'h55 ^ 7'(s);
         for (int k = 0; k < nseg; k++)
            if (s == ends[k]) mod_code_i = 7'(code_a[k]);
         @(negedge clk);
      end
   endtask

   task automatic hold_reset();
      @(negedge clk);
      #0.5 rst_ni = 1'b0;
      for (int i = 0; i < 4; i++) begin
         #0.5;
         chk(cyc_end_o, 1'b0, "R1 reset end", -1);
         chk(div_o, 1'b0, "R1 reset div", -1);
         chk(bias_en_o, 1'b0, "R1 reset bias", -1);
         chk(dac_en_o, 1'b0, "R1 reset dac", -1);
         @(negedge clk);
      end
      rst_ni = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      mod_code_i = 7'h2a;
      hold_reset();
      nseg = NC;
      for (int k = 0; k < NC; k++) begin
         code_a[k] = TBL[k][0];
         per_a[k]  = TBL[k][1];
      end
      run_seq();

      // Directed: reset in mid-period, then two maximum periods and a minimum one.
      hold_reset();
      nseg = 3;
      code_a[0] = 127; per_a[0] = 255;
      code_a[1] = 127; per_a[1] = 255;
      code_a[2] = 0;   per_a[2] = 128;
      run_seq();

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule